// File: doc/BRIEF.md
# Cascaded Serial Control-Word Port

This block is the serial control front of a converter that can be chained with up to seven identical neighbours. Sixteen-bit words arrive one bit per clock, most significant bit first, with a one-cycle frame marker on the first bit. Each word is decoded according to the current operating mode. It may write one of eight 8-bit configuration registers, read one of them back, be passed toward the next device with its address counted down, or be dropped. Addressing depends on position in the chain: the device that sees a zero in the 3-bit address field consumes the word, and every device before it lowers the field by one.

Outgoing frames use the timing of the incoming ones. On each incoming frame marker the block loads a 16-bit word and shifts it out, again most significant bit first. That word is one of three things, in this order of priority: a pending forwarded word, a pending read reply, or a sample-slot word. The sample-slot word depends on the mode: a fixed filler in Program mode, the parallel sample input as it stands in Data mode, and the sample with its top bit cleared in Mixed mode. The mode comes from the two low bits of register 0. Data mode can only be left through reset.

Top module: `chain_ctl_port`

## Requirements
- R1: Synchronous active-low reset clears all eight registers to 0x00, selects Program mode (mode_o = 0), and drives sdo, sdo_fs and wr_stb low.
- R2: Frames are 16 bits, MSB first, one bit per clock, with sdi_fs high on the first bit. On the cycle after each sdi_fs, sdo_fs is high and sdo carries bit 15 of the outgoing word. The remaining bits follow one per cycle.
- R3: A control word carries a read flag in bit 14 (1 = read), a device address in bits 13:11, a register index in bits 10:8 and register data in bits 7:0. An accepted word with address 0 and bit 14 = 0 writes the data into the indexed register. wr_stb is then high for one cycle, the cycle after the word's last bit, with wr_idx and wr_data set to the index and data.
- R4: An accepted word with a non-zero address is not applied locally. It is sent out in the next frame slot with its address field reduced by one and all other bits unchanged.
- R5: An accepted word with address 0 and bit 14 = 1 is answered in the next frame slot. The reply keeps bits 15:8 of the request and has the indexed register's contents in bits 7:0.
- R6: The mode follows register 0: bit 0 = 0 gives Program (mode_o = 0); bit 0 = 1 with bit 1 = 0 gives Data (mode_o = 1); bits 1:0 = 11 gives Mixed (mode_o = 2). A write to register 0 changes mode_o on the wr_stb cycle.
- R7: In Data mode every incoming word is ignored: nothing is written, read or forwarded. The mode stays Data until reset.
- R8: In Program mode every word is accepted as control, whatever bit 15 holds. In Mixed mode, words with bit 15 = 1 are accepted as control, and words with bit 15 = 0 are ignored.
- R9: When nothing is pending, the outgoing word is the filler 0x0000 in Program mode. In Data mode it is sample_in as captured on the sdi_fs cycle. In Mixed mode it is that sample with bit 15 forced to 0.
- R10: Mixed mode can be selected by the very first write after reset.
- R11: A pending forwarded word or read reply takes the next slot in place of the sample-slot word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial input bit |
| sdi_fs | input | 1 | Frame marker, high on the first incoming bit |
| sample_in | input | 16 | Parallel sample word for the sample slot |
| sdo | output | 1 | Serial output bit |
| sdo_fs | output | 1 | Outgoing frame marker, high with bit 15 |
| mode_o | output | 2 | Operating mode: 0 Program, 1 Data, 2 Mixed |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_idx | output | 3 | Index of the written register |
| wr_data | output | 8 | Value written |

## Verification
The bench builds the block with its default parameters: 16-bit words, a 3-bit address field, eight 8-bit registers and a filler of 0x0000. With these values every address from 0 to 7 can be driven, so forwarding is exercised from the top address down and a read of each register index is possible. All three modes are reachable within one run, along with the reset path out of Data mode and the back-to-back frame case, in which a decision on one word's last bit must be ready at the next frame marker.

// File: rtl/chain_ctl_pkg.sv
// Shared word layout and mode encoding for the cascaded control-word port.
// Assumes the fixed 16-bit frame: flag, read flag, address, index, data.
package chain_ctl_pkg;
    localparam int ADDR_W   = 3;
    localparam int IDX_W    = 3;
    localparam int DATA_W   = 8;
    localparam int WORD_W   = 2 + ADDR_W + IDX_W + DATA_W;
    localparam int REG_N    = 1 << IDX_W;
    localparam int FLAG_BIT = WORD_W - 1;
    localparam int RW_BIT   = WORD_W - 2;
    localparam int ADDR_LSB = IDX_W + DATA_W;
    localparam int IDX_LSB  = DATA_W;

    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_MIXED = 2'd2
    } mode_e;
endpackage

// File: rtl/ccp_deser.sv
// Serial-to-parallel receiver. Counts W bits from the frame marker, MSB
// first. On the last bit it presents the complete word combinationally,
// so a decision can be registered at that edge and be ready for a frame
// that follows without a gap. Assumes markers are at least W cycles apart.
module ccp_deser #(
    parameter int W = chain_ctl_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         sdi_fs,
    output logic         done_o,
    output logic [W-1:0] word_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     sh_q;
    logic [CNT_W-1:0] cnt_q;

    // Shift in one bit per cycle and track the position inside the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (sdi_fs) begin
            sh_q  <= {{(W-1){1'b0}}, sdi};
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != '0) begin
            sh_q  <= {sh_q[W-2:0], sdi};
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // Flag the last bit and assemble the full word around it.
    always_comb begin
        done_o = !sdi_fs && (cnt_q == LAST);
        word_o = {sh_q[W-2:0], sdi};
    end
endmodule

// File: rtl/ccp_decode.sv
// Control-word classifier. Given the current mode and a completed word, it
// decides among local write, local read, forward with the address lowered
// by one, and drop. Purely combinational; the register read data comes back
// from the register file for the index it requests.
module ccp_decode
    import chain_ctl_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int AW = ADDR_W,
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  mode_e         mode_i,
    input  logic          done_i,
    input  logic [W-1:0]  word_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [IW-1:0] idx_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_data_o,
    output logic          resp_vld_o,
    output logic [W-1:0]  resp_word_o
);
    logic          accept;
    logic          here;
    logic          is_rd;
    logic [AW-1:0] addr;
    logic [W-1:0]  fwd_word;
    logic [W-1:0]  rd_word;

    // Decide whether the word is control for this mode, and where it goes.
    always_comb begin
        unique case (mode_i)
            MODE_PROG:  accept = done_i;
            MODE_MIXED: accept = done_i && word_i[FLAG_BIT];
            default:    accept = 1'b0;
        endcase
        addr      = word_i[ADDR_LSB +: AW];
        here      = (addr == '0);
        is_rd     = word_i[RW_BIT];
        idx_o     = word_i[IDX_LSB +: IW];
        wr_data_o = word_i[DW-1:0];
        wr_en_o   = accept && here && !is_rd;
    end

    // Build the reply word: lowered address for forwarding, data for a read.
    always_comb begin
        fwd_word                      = word_i;
        fwd_word[ADDR_LSB +: AW]      = addr - AW'(1);
        rd_word                       = word_i;
        rd_word[DW-1:0]               = rd_data_i;
        resp_vld_o                    = accept && (!here || is_rd);
        resp_word_o                   = here ? rd_word : fwd_word;
    end
endmodule

// File: rtl/ccp_regs.sv
// Configuration register file with the mode decode. One register per index,
// written only through the decoder's write enable. The mode is taken from
// register 0, so reset alone returns the block to Program mode. Write strobe
// outputs are registered alongside the write.
module ccp_regs
    import chain_ctl_pkg::*;
#(
    parameter int N  = REG_N,
    parameter int IW = IDX_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rd_data_o,
    output mode_e         mode_o,
    output logic          wr_stb_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [DW-1:0] wr_data_o
);
    logic [DW-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [DW-1:0] q;
        // Hold one register; load it when the write names this index.
        always_ff @(posedge clk) begin
            if (!rst_n)                               q <= '0;
            else if (wr_en_i && (idx_i == IW'(g)))    q <= wdata_i;
        end
        assign regs[g] = q;
    end

    // Read port and mode decode from the two low bits of register 0.
    always_comb begin
        rd_data_o = regs[idx_i];
        if (!regs[0][0])     mode_o = MODE_PROG;
        else if (regs[0][1]) mode_o = MODE_MIXED;
        else                 mode_o = MODE_DATA;
    end

    // Register the write strobe with its index and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb_o  <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_stb_o  <= wr_en_i;
            wr_idx_o  <= idx_i;
            wr_data_o <= wdata_i;
        end
    end

    // R7
    write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> ($past(mode_o) != MODE_DATA));

    // R7
    data_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_o) == MODE_DATA) |-> (mode_o == MODE_DATA));
endmodule

// File: rtl/ccp_ser.sv
// Outgoing word selection and parallel-to-serial shifter. A single pending
// slot holds a forwarded word or a read reply. The slot is filled on a
// word's last bit and emptied at the next frame marker. With no pending word,
// the sample slot is filled according to the mode. Assumes at most one
// reply per frame, which holds because each frame carries one word.
module ccp_ser
    import chain_ctl_pkg::*;
#(
    parameter int           W    = WORD_W,
    parameter logic [W-1:0] FILL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         resp_vld_i,
    input  logic [W-1:0] resp_word_i,
    input  mode_e        mode_i,
    input  logic [W-1:0] sample_i,
    output logic         sdo,
    output logic         sdo_fs
);
    logic         pend_q;
    logic [W-1:0] pend_word_q;
    logic [W-1:0] next_word;
    logic [W-1:0] sh_q;

    // Capture a reply at a word's end; release the slot at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_word_q <= '0;
        end else if (load_i) begin
            pend_q      <= 1'b0;
        end else if (resp_vld_i) begin
            pend_q      <= 1'b1;
            pend_word_q <= resp_word_i;
        end
    end

    // Choose the word for the coming slot: pending reply first, else sample slot.
    always_comb begin
        if (pend_q) begin
            next_word = pend_word_q;
        end else begin
            unique case (mode_i)
                MODE_DATA:  next_word = sample_i;
                MODE_MIXED: next_word = {1'b0, sample_i[W-2:0]};
                default:    next_word = FILL;
            endcase
        end
    end

    // Load on the frame marker and shift out one bit per cycle, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sdo    <= 1'b0;
            sdo_fs <= 1'b0;
        end else begin
            sdo_fs <= load_i;
            if (load_i) begin
                sdo  <= next_word[W-1];
                sh_q <= {next_word[W-2:0], 1'b0};
            end else begin
                sdo  <= sh_q[W-1];
                sh_q <= {sh_q[W-2:0], 1'b0};
            end
        end
    end

    // R9
    mixed_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_fs && $past(rst_n) && $past(mode_i) == MODE_MIXED && !$past(pend_q)) |-> !sdo);
endmodule

// File: rtl/chain_ctl_port.sv
// Top of the cascaded control-word port. Connects the receiver, the decoder,
// the register file with its mode decode, and the transmitter. The outgoing
// frame timing is taken from the incoming frame marker, so each word received
// in one slot is answered in the next. Assumes one word per frame and frame
// markers at least 16 cycles apart.
module chain_ctl_port
    import chain_ctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] FILL_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              sdi_fs,
    input  logic [WORD_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_fs,
    output logic [1:0]        mode_o,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data
);
    logic              done;
    logic [WORD_W-1:0] word;
    mode_e             mode;
    logic [IDX_W-1:0]  idx;
    logic              wr_en;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_data;
    logic              resp_vld;
    logic [WORD_W-1:0] resp_word;

    ccp_deser #(.W(WORD_W)) rx_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdi    (sdi),
        .sdi_fs (sdi_fs),
        .done_o (done),
        .word_o (word)
    );

    ccp_decode #(.W(WORD_W), .AW(ADDR_W), .IW(IDX_W), .DW(DATA_W)) dec_i (
        .mode_i      (mode),
        .done_i      (done),
        .word_i      (word),
        .rd_data_i   (rd_data),
        .idx_o       (idx),
        .wr_en_o     (wr_en),
        .wr_data_o   (wdata),
        .resp_vld_o  (resp_vld),
        .resp_word_o (resp_word)
    );

    ccp_regs #(.N(REG_N), .IW(IDX_W), .DW(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .idx_i     (idx),
        .wdata_i   (wdata),
        .rd_data_o (rd_data),
        .mode_o    (mode),
        .wr_stb_o  (wr_stb),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    ccp_ser #(.W(WORD_W), .FILL(FILL_WORD)) tx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (sdi_fs),
        .resp_vld_i  (resp_vld),
        .resp_word_i (resp_word),
        .mode_i      (mode),
        .sample_i    (sample_in),
        .sdo         (sdo),
        .sdo_fs      (sdo_fs)
    );

    // Present the mode as its two-bit code.
    always_comb mode_o = mode;

    // R3
    write_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(done));

    // R6
    mode_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && mode_o != $past(mode_o)) |-> (wr_stb && wr_idx == '0));
endmodule

// File: tb/chain_ctl_port_tb_top.sv
`timescale 1ns/1ps
module chain_ctl_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sdi_fs = 1'b0;
    logic [15:0] sample_in = '0;
    logic        sdo, sdo_fs, wr_stb;
    logic [1:0]  mode_o;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails  = 0;
    bit done_run = 0;

    logic [15:0] exp_out_q[$];
    string       exp_tag_q[$];
    logic [10:0] exp_wr_q[$];

    logic [7:0]  m_regs [8];
    logic [1:0]  m_mode;
    bit          m_pend;
    logic [15:0] m_pend_w;
    string       m_pend_tag;

    always #2 clk = ~clk;

    chain_ctl_port dut_i (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs), .sample_in(sample_in),
        .sdo(sdo), .sdo_fs(sdo_fs), .mode_o(mode_o), .wr_stb(wr_stb),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] mode_of(logic [7:0] r0);
        if (!r0[0]) return 2'd0;
        return r0[1] ? 2'd2 : 2'd1;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_mode = 2'd0;
        m_pend = 0;
    endfunction

    // Driver: predicts this slot's outgoing word, sends the frame, then applies the word to the model.
    task automatic send(logic [15:0] w, logic [15:0] smp);
        logic [2:0] a;
        bit ctl;
        if (m_pend) begin
            exp_out_q.push_back(m_pend_w); exp_tag_q.push_back(m_pend_tag); m_pend = 0;
        end else begin
            case (m_mode)
                2'd1:    begin exp_out_q.push_back(smp); exp_tag_q.push_back("R9 R7 data-mode sample"); end
                2'd2:    begin exp_out_q.push_back({1'b0, smp[14:0]}); exp_tag_q.push_back("R9 mixed sample"); end
                default: begin exp_out_q.push_back(16'h0000); exp_tag_q.push_back("R9 program filler"); end
            endcase
        end
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            sdi_fs = (i == 0);
            sdi = w[15 - i];
            if (i == 0) sample_in = smp;
        end
        ctl = (m_mode == 2'd0) || (m_mode == 2'd2 && w[15]);
        a = w[13:11];
        if (ctl) begin
            if (a != 3'd0) begin
                m_pend = 1; m_pend_w = {w[15:14], a - 3'd1, w[10:0]}; m_pend_tag = "R4 R11 forward";
            end else if (w[14]) begin
                m_pend = 1; m_pend_w = {w[15:8], m_regs[w[10:8]]}; m_pend_tag = "R5 R11 read reply";
            end else begin
                m_regs[w[10:8]] = w[7:0];
                exp_wr_q.push_back({w[10:8], w[7:0]});
                if (w[10:8] == 3'd0) m_mode = mode_of(w[7:0]);
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sdi_fs = 1'b0;
            sdi = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sdi_fs = 1'b0; sdi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: gathers each outgoing frame and compares it with the scoreboard.
    int          oc = 0;
    logic [15:0] acc = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sdo_fs) begin
                acc = {15'b0, sdo}; oc = 1;
            end else if (oc > 0) begin
                acc = {acc[14:0], sdo}; oc++;
            end
            if (oc == 16) begin
                oc = 0;
                if (exp_out_q.size() == 0) check("R2", "unexpected outgoing frame", 32'(acc), 32'hFFFFFFFF);
                else check(exp_tag_q.pop_front(), "outgoing word", 32'(acc), 32'(exp_out_q.pop_front()));
            end
        end else oc = 0;
    end

    // Monitor: every write strobe must match the next predicted write.
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_wr_q.size() == 0) check("R7 R8", "unexpected write", 32'({wr_idx, wr_data}), 32'hFFFFFFFF);
            else check("R3", "write strobe idx/data", 32'({wr_idx, wr_data}), 32'(exp_wr_q.pop_front()));
        end
    end

    task automatic chk_mode(string tag, logic [1:0] exp);
        @(negedge clk);
        check(tag, "mode_o", 32'(mode_o), 32'(exp));
    endtask

    task automatic drain(string tag);
        idle(24);
        check(tag, "outgoing frames left", 32'(exp_out_q.size()), 0);
        check("R3", "writes left", 32'(exp_wr_q.size()), 0);
    endtask

    initial begin
        model_reset();
        do_reset();
        @(negedge clk);
        check("R1", "mode after reset", 32'(mode_o), 0);
        check("R1", "sdo after reset", 32'(sdo), 0);
        check("R1", "sdo_fs after reset", 32'(sdo_fs), 0);
        check("R1", "wr_stb after reset", 32'(wr_stb), 0);

        // Program mode: R1 zero read, R3 write, R5 read, R4 forward, R8 flag ignored
        send(16'h4300, 16'h1234);
        send(16'h03A5, 16'h1234);
        send(16'h4300, 16'h1234);
        send(16'h2A11, 16'h5555);
        send(16'h7F00, 16'h5555);
        idle(3);
        send(16'h8312, 16'h0000);
        send(16'h4300, 16'h0000);
        chk_mode("R6 program", 2'd0);

        // Mixed mode
        send(16'h0003, 16'h0000);
        chk_mode("R6 mixed", 2'd2);
        send(16'h0255, 16'hFFFF);   // R8: flag clear, dropped
        send(16'hC200, 16'h8001);
        send(16'h8277, 16'hFFFF);   // R8: flagged write
        send(16'hC200, 16'hFFFF);
        send(16'h8900, 16'hFFFF);   // R11: forward beats sample
        send(16'h0900, 16'hABCD);   // R8: flag clear, not forwarded
        send(16'h0000, 16'hABCD);
        idle(2);

        // Data mode: R7 everything dropped
        send(16'h8001, 16'h0000);
        chk_mode("R6 data", 2'd1);
        send(16'h0002, 16'h8123);
        send(16'h8003, 16'hFEDC);
        send(16'h4300, 16'h0F0F);
        send(16'h8B00, 16'hA0A0);
        send(16'h0000, 16'h7777);
        chk_mode("R7 data lock", 2'd1);
        drain("R7");

        // Reset leaves Data mode; R10 mixed on first write
        do_reset();
        chk_mode("R7 reset exit", 2'd0);
        send(16'h0003, 16'h0000);
        chk_mode("R10 first-write mixed", 2'd2);
        send(16'hC300, 16'h4444);   // R1: register 3 cleared by reset
        send(16'h0000, 16'h9999);
        drain("R2");

        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule